// File: doc/BRIEF.md
# Buffered SPI Master Command Engine

This block is a register-mapped SPI master that shifts an entire message out of an on-chip transmit buffer in response to a single command write. Software fills the transmit buffer one byte at a time, writes a message-control word with a byte count and a transfer type, and then writes a command word. The command word carries a start code, an optional count of write-only lead-in bytes, and a device number. The engine holds the chosen chip select low for the whole command. It drives SCLK and MOSI, stores the MISO bytes of the main phase in a receive buffer, and reports how many bytes it stored. When the command finishes it sets a done flag that can raise an interrupt.

The lead-in bytes let a short command or address go out before a read within the same chip-select window. This is needed because chip select cannot be held between commands. The SCLK rate comes from a 3-bit code that divides the system clock by a power of two. Clock polarity and phase can be set, and every word is 8 bits wide, most significant bit first.

Top module: `spi_cmd_engine`

## Requirements
- R1: A write to the command register (address 0x81) starts a command only when bits [3:0] equal 0x1. A write carrying any other code has no effect: no chip select, no busy, no done.
- R2: The message-control register (0x80) holds the main-phase byte count in bits [6:0] and the type in bits [9:8]. Type 0 is full duplex (transmit buffer bytes out, MISO stored). Type 1 is write-only. Types 2 and 3 are read-only.
- R3: Command bits [7:4] give a lead-in count P (0..15). Transmit bytes 0..P-1 go out first and nothing is stored for them. The main phase then continues from transmit byte P, so the slave sees P+N bytes in one window.
- R4: If P+N exceeds the 64-byte buffer depth, the command is dropped. Status bit 1 (error) is set, and no chip select, busy or done follows.
- R5: Command bits [9:8] select which cs_n line goes low. Exactly one line is asserted, in one unbroken low period from the start write until right after the last byte. All lines are high while idle.
- R6: The receive-tail register (0x85) reads the number of bytes stored by the last command. This is N for full-duplex and read commands. Stored main-phase byte k reads back at address 0x40+k.
- R7: The status register (0x83) has bit 0 done, bit 1 error and bit 2 busy. irq is high one cycle after done is set, and only while mask register (0x84) bit 0 is 1. Writing 1 to a status bit clears it, so 0x3 clears everything pending.
- R8: Clock-config register (0x82) bits [2:0] hold a code c. The SCLK period is 2^(c+1) system clocks for c = 0..6. Code 7 gives the same period as code 6.
- R9: Clock-config bit 3 is the SCLK idle level and bit 4 the phase. With phase 0 both sides sample on the leading edge; with phase 1 they sample on the trailing edge. Each byte is 8 bits, MSB first.
- R10: In write-only mode MISO is ignored: the tail reads 0 and the receive buffer keeps its old contents. In read-only mode MOSI is low for every main-phase bit.
- R11: Busy reads 1 from the accepted start write until done is set. A start write arriving while busy is ignored.
- R12: Transmit bytes are written at 0x00..0x3F from bus_wdata[7:0]. Any register or receive-buffer read presents its data on bus_rdata in the cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register/buffer write strobe |
| bus_rd | input | 1 | Register/buffer read strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Masked command-done interrupt |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to the slave |
| miso | input | 1 | SPI data from the slave |
| cs_n | output | 4 | Active-low chip selects, one per device |

## Verification
The bench attaches a mode-aware slave model. It records every MOSI byte and returns a known MISO pattern, so a lead-in phase that stored data, or that restarted the main phase at buffer byte 0, shows up as shifted receive contents or a wrong tail count. Maximum lead-in with a read and a full 64-byte frame check the boundaries. An off-by-one in the size limit either drops a legal frame or accepts the 65-byte request. A second start issued while busy must not cause a second chip-select assertion or redirect the first one. The sampled period for codes 0, 3 and 7 exposes a divider that mishandles the saturating top code.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    MT_FULL     = 2'd0,
    MT_WRITE    = 2'd1,
    MT_READ     = 2'd2,
    MT_READ_ALT = 2'd3
  } msg_type_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_LOAD,
    SQ_SHIFT,
    SQ_FINISH
  } seq_state_e;

  localparam logic [3:0] START_CODE = 4'h1;

  // register offsets above the two buffer windows
  localparam int OFS_MSG  = 0;
  localparam int OFS_CMD  = 1;
  localparam int OFS_CLK  = 2;
  localparam int OFS_STAT = 3;
  localparam int OFS_MASK = 4;
  localparam int OFS_TAIL = 5;

  function automatic logic is_read_type(msg_type_e t);
    return (t == MT_READ) || (t == MT_READ_ALT);
  endfunction

endpackage

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // one write port, one registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int CODE_W    = 3,
  parameter int SLOW_CODE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  localparam int CW = SLOW_CODE + 1;

  logic [CODE_W-1:0] eff;
  logic [CW-1:0]     lim;
  logic [CW-1:0]     cnt;

  // codes above the slowest saturate to it
  assign eff  = (code > CODE_W'(SLOW_CODE)) ? CODE_W'(SLOW_CODE) : code;
  assign lim  = (CW'(1) << eff) - CW'(1);
  assign tick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_byte
);

  localparam int EDGES = 2 * WORD_W;
  localparam int EC_W  = $clog2(EDGES);

  logic              active;
  logic              ph;
  logic              mosi_q;
  logic              done_q;
  logic [EC_W-1:0]   ecnt;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] rx;
  logic              sample_edge;

  // even edge count = leading edge; phase 0 samples there, phase 1 on trailing
  assign sample_edge = (~ecnt[0]) ^ cpha;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ph     <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      ecnt   <= '0;
      sh     <= '0;
      rx     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active <= 1'b1;
        ecnt   <= '0;
        ph     <= 1'b0;
        if (!cpha) begin
          mosi_q <= tx_byte[WORD_W-1];
          sh     <= {tx_byte[WORD_W-2:0], 1'b0};
        end else begin
          sh <= tx_byte;
        end
      end else if (active && tick) begin
        ph   <= ~ph;
        ecnt <= ecnt + EC_W'(1);
        if (sample_edge) begin
          rx <= {rx[WORD_W-2:0], miso};
        end else begin
          mosi_q <= sh[WORD_W-1];
          sh     <= {sh[WORD_W-2:0], 1'b0};
        end
        if (ecnt == EC_W'(EDGES - 1)) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sclk    = ph ^ cpol;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign rx_byte = rx;

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> (ph == 1'b0)); // R9

  AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(active)); // R9

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 64,
  parameter int NUM_CS    = 4,
  parameter int PRE_MAX   = 15,
  parameter int SLOW_CODE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int BUF_AW   = $clog2(BUF_DEPTH);
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1);
  localparam int PRE_W    = $clog2(PRE_MAX + 1);
  localparam int DEV_W    = $clog2(NUM_CS);
  localparam int SUM_W    = ((CNT_W > PRE_W) ? CNT_W : PRE_W) + 1;
  localparam int REG_BASE = 2 * BUF_DEPTH;
  localparam int TYPE_LSB = 8;
  localparam int PRE_LSB  = 4;
  localparam int DEV_LSB  = 8;

  // ---------------- address decode ----------------
  logic tx_hit, rx_hit, is_msg, is_cmd, is_clk, is_stat, is_mask, is_tail;
  assign tx_hit  = bus_addr <  ADDR_W'(BUF_DEPTH);
  assign rx_hit  = (bus_addr >= ADDR_W'(BUF_DEPTH)) && (bus_addr < ADDR_W'(REG_BASE));
  assign is_msg  = bus_addr == ADDR_W'(REG_BASE + OFS_MSG);
  assign is_cmd  = bus_addr == ADDR_W'(REG_BASE + OFS_CMD);
  assign is_clk  = bus_addr == ADDR_W'(REG_BASE + OFS_CLK);
  assign is_stat = bus_addr == ADDR_W'(REG_BASE + OFS_STAT);
  assign is_mask = bus_addr == ADDR_W'(REG_BASE + OFS_MASK);
  assign is_tail = bus_addr == ADDR_W'(REG_BASE + OFS_TAIL);

  // ---------------- configuration registers ----------------
  logic [CNT_W-1:0] cnt_q;
  msg_type_e        type_q;
  logic [2:0]       code_q;
  logic             cpol_q, cpha_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      type_q <= MT_FULL;
      code_q <= '0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (bus_wr) begin
      if (is_msg) begin
        cnt_q  <= bus_wdata[CNT_W-1:0];
        type_q <= msg_type_e'(bus_wdata[TYPE_LSB +: 2]);
      end
      if (is_clk) begin
        code_q <= bus_wdata[2:0];
        cpol_q <= bus_wdata[3];
        cpha_q <= bus_wdata[4];
      end
      if (is_mask) mask_q <= bus_wdata[0];
    end
  end

  // ---------------- sequencer ----------------
  seq_state_e       st;
  msg_type_e        run_type;
  logic [SUM_W-1:0] idx, pre_q, total_q;
  logic [SUM_W-1:0] req_pre, req_total;
  logic [DEV_W-1:0] req_dev;
  logic [NUM_CS-1:0] cs_n_q;
  logic [CNT_W-1:0] tail_q;
  logic             done_q, err_q, irq_q;
  logic             start_req, in_main, last_byte, store;
  logic             sh_start, sh_done;
  logic [7:0]       tx_q, rx_q, sh_rx, sh_tx;
  logic [BUF_AW-1:0] rx_waddr;
  logic             tick;

  assign req_pre   = SUM_W'(bus_wdata[PRE_LSB +: PRE_W]);
  assign req_total = req_pre + SUM_W'(cnt_q);
  assign req_dev   = bus_wdata[DEV_LSB +: DEV_W];
  assign start_req = bus_wr && is_cmd && (bus_wdata[3:0] == START_CODE) && (st == SQ_IDLE);
  assign in_main   = idx >= pre_q;
  assign last_byte = (idx + SUM_W'(1)) == total_q;
  assign store     = sh_done && in_main && (run_type != MT_WRITE);
  assign rx_waddr  = BUF_AW'(idx - pre_q);
  assign sh_start  = (st == SQ_LOAD);
  assign sh_tx     = (in_main && is_read_type(run_type)) ? 8'h00 : tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      run_type <= MT_FULL;
      idx      <= '0;
      pre_q    <= '0;
      total_q  <= '0;
      cs_n_q   <= '1;
      tail_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      // write-one-to-clear; a set in the same cycle below wins
      if (bus_wr && is_stat) begin
        done_q <= done_q & ~bus_wdata[0];
        err_q  <= err_q  & ~bus_wdata[1];
      end
      case (st)
        SQ_IDLE: begin
          if (start_req) begin
            if (req_total > SUM_W'(BUF_DEPTH)) begin
              err_q <= 1'b1;
            end else begin
              pre_q    <= req_pre;
              total_q  <= req_total;
              idx      <= '0;
              run_type <= type_q;
              tail_q   <= '0;
              if (req_total == '0) begin
                st <= SQ_FINISH;
              end else begin
                cs_n_q <= ~(NUM_CS'(1) << req_dev);
                st     <= SQ_FETCH;
              end
            end
          end
        end
        SQ_FETCH: st <= SQ_LOAD;
        SQ_LOAD:  st <= SQ_SHIFT;
        SQ_SHIFT: begin
          if (sh_done) begin
            if (store) tail_q <= tail_q + CNT_W'(1);
            idx <= idx + SUM_W'(1);
            if (last_byte) begin
              cs_n_q <= '1;
              st     <= SQ_FINISH;
            end else begin
              st <= SQ_FETCH;
            end
          end
        end
        SQ_FINISH: begin
          done_q <= 1'b1;
          st     <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= done_q && mask_q;
  end

  // ---------------- datapath instances ----------------
  spi_byte_ram #(.DEPTH(BUF_DEPTH), .WIDTH(8)) u_tx_ram (
    .clk   (clk),
    .we    (bus_wr && tx_hit),
    .waddr (bus_addr[BUF_AW-1:0]),
    .wdata (bus_wdata[7:0]),
    .raddr (idx[BUF_AW-1:0]),
    .rdata (tx_q)
  );

  spi_byte_ram #(.DEPTH(BUF_DEPTH), .WIDTH(8)) u_rx_ram (
    .clk   (clk),
    .we    (store),
    .waddr (rx_waddr),
    .wdata (sh_rx),
    .raddr (bus_addr[BUF_AW-1:0]),
    .rdata (rx_q)
  );

  spi_rate_gen #(.CODE_W(3), .SLOW_CODE(SLOW_CODE)) u_rate (
    .clk   (clk),
    .rst   (rst),
    .clear (sh_start),
    .code  (code_q),
    .tick  (tick)
  );

  spi_byte_shifter #(.WORD_W(8)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .cpol    (cpol_q),
    .cpha    (cpha_q),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .tick    (tick),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  // ---------------- read-back ----------------
  logic              rd_rx_q;
  logic [DATA_W-1:0] rd_reg_q;
  logic [DATA_W-1:0] reg_word;

  always_comb begin
    reg_word = '0;
    if (is_msg) begin
      reg_word[CNT_W-1:0]       = cnt_q;
      reg_word[TYPE_LSB +: 2]   = type_q;
    end else if (is_clk) begin
      reg_word[4:0] = {cpha_q, cpol_q, code_q};
    end else if (is_stat) begin
      reg_word[2:0] = {(st != SQ_IDLE), err_q, done_q};
    end else if (is_mask) begin
      reg_word[0] = mask_q;
    end else if (is_tail) begin
      reg_word[CNT_W-1:0] = tail_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_rx_q  <= 1'b0;
      rd_reg_q <= '0;
    end else if (bus_rd) begin
      rd_rx_q  <= rx_hit;
      rd_reg_q <= reg_word;
    end
  end

  assign bus_rdata = rd_rx_q ? DATA_W'(rx_q) : rd_reg_q;
  assign irq       = irq_q;
  assign cs_n      = cs_n_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:TYPE_LSB+2];

  // ---------------- assertions ----------------
  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n_q) <= 1); // R5

  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE) |-> (&cs_n_q)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tail_q <= CNT_W'(BUF_DEPTH)); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (st == SQ_IDLE)); // R11

  AST_WRITE_NO_TAIL: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE && run_type == MT_WRITE) |-> (tail_q == '0)); // R10

endmodule

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  wire  [15:0] bus_rdata;
  wire         irq, sclk, mosi;
  logic        miso_r = 1'b0;
  wire  [3:0]  cs_n;

  always #2 clk = ~clk;

  spi_cmd_engine dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso_r), .cs_n(cs_n)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_pat(int i);
    return 8'(17 + i * 13);
  endfunction

  function automatic logic [7:0] slave_byte(int n);
    return 8'hA5 ^ 8'(n * 29);
  endfunction

  // ---------------- slave model ----------------
  logic       b_cpol = 1'b0, b_cpha = 1'b0;
  logic [7:0] mosi_log [0:127];
  logic [7:0] rec = '0;
  logic [3:0] cs_seen = '1;
  logic       sclk_prev = 1'b0, cs_prev = 1'b0;
  int         slave_n = 0, bitcnt = 0, cs_falls = 0, samp_edges = 0;
  time        t_s0 = 0, t_s1 = 0;

  always @(negedge clk) begin
    logic act, samp;
    logic [7:0] bb;
    act = (cs_n != 4'hF);
    if (act && !cs_prev) begin
      cs_falls++;
      cs_seen = cs_n;
      slave_n = 0;
      bitcnt  = 0;
      if (!b_cpha) begin
        bb = slave_byte(0);
        miso_r = bb[7];
      end
    end else if (act && (sclk != sclk_prev)) begin
      samp = sclk ? (b_cpol == b_cpha) : (b_cpol != b_cpha);
      if (samp) begin
        rec = {rec[6:0], mosi};
        if (samp_edges == 0) t_s0 = $time;
        if (samp_edges == 1) t_s1 = $time;
        samp_edges++;
        bitcnt++;
        if (bitcnt == 8) begin
          if (slave_n < 128) mosi_log[slave_n] = rec;
          slave_n++;
          bitcnt = 0;
        end
      end else begin
        bb = slave_byte(slave_n);
        miso_r = bb[7 - bitcnt];
      end
    end
    sclk_prev = sclk;
    cs_prev   = act;
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic fill_tx();
    for (int i = 0; i < 64; i++) bus_write(8'(i), 16'(tx_pat(i)));
  endtask

  task automatic start_cmd(input int typ, input int pre, input int n, input int dev,
                           input int code, input int cpol, input int cpha, input int scode);
    b_cpol = 1'(cpol);
    b_cpha = 1'(cpha);
    bus_write(8'h82, 16'(code | (cpol << 3) | (cpha << 4)));
    bus_write(8'h80, 16'(n | (typ << 8)));
    cs_falls = 0; slave_n = 0; samp_edges = 0;
    bus_write(8'h81, 16'(scode | (pre << 4) | (dev << 8)));
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    for (int k = 0; k < 20000; k++) begin
      bus_read(8'h83, d);
      if (!d[2]) break;
    end
  endtask

  task automatic verify(input string tag, input int typ, input int pre, input int n, input int dev);
    logic [15:0] d;
    logic [7:0]  e;
    check("R5", {tag, " cs assertions"}, 32'(cs_falls), 1);
    check("R5", {tag, " cs line"}, 32'(cs_seen), 32'(4'(~(4'd1 << dev))));
    check("R3", {tag, " bytes seen by slave"}, 32'(slave_n), 32'(pre + n));
    for (int j = 0; j < pre + n; j++) begin
      e = (typ == 2 && j >= pre) ? 8'h00 : tx_pat(j);
      check((typ == 2 && j >= pre) ? "R10" : "R9", {tag, " mosi byte"}, 32'(mosi_log[j]), 32'(e));
    end
    bus_read(8'h83, d);
    check("R7", {tag, " status done/busy"}, 32'(d[2:0]), 32'h1);
    bus_read(8'h85, d);
    check("R6", {tag, " rx tail"}, 32'(d), 32'((typ == 1) ? 0 : n));
    if (typ != 1) begin
      for (int k = 0; k < n; k++) begin
        bus_read(8'(8'h40 + k), d);
        check("R6 R12", {tag, " rx byte"}, 32'(d), 32'(slave_byte(pre + k)));
      end
    end
    bus_write(8'h83, 16'h3);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [15:0] d;
    bus_read(8'h83, d);
    check("R7", "reset status", 32'(d), 0);
    bus_read(8'h85, d);
    check("R6", "reset tail", 32'(d), 0);
    check("R7", "reset irq", 32'(irq), 0);
    check("R5", "reset cs_n", 32'(cs_n), 32'hF);
  endtask

  task automatic t_full_duplex();
    start_cmd(0, 0, 4, 0, 0, 0, 0, 1);
    wait_idle();
    verify("R2 full duplex", 0, 0, 4, 0);
  endtask

  task automatic t_write_prepend();
    logic [15:0] d;
    start_cmd(1, 3, 5, 2, 1, 1, 1, 1);
    wait_idle();
    verify("R2 write-only", 1, 3, 5, 2);
    bus_read(8'h40, d);
    check("R10", "rx buffer untouched by write-only", 32'(d), 32'(slave_byte(0)));
  endtask

  task automatic t_read_prepend();
    start_cmd(2, 15, 8, 1, 1, 0, 1, 1);
    wait_idle();
    verify("R3 max lead-in read", 2, 15, 8, 1);
  endtask

  task automatic t_full_buffer();
    start_cmd(0, 0, 64, 3, 0, 1, 0, 1);
    wait_idle();
    verify("R4 64-byte frame", 0, 0, 64, 3);
  endtask

  task automatic t_oversize();
    logic [15:0] d;
    start_cmd(0, 15, 50, 0, 0, 0, 0, 1);
    repeat (40) @(negedge clk);
    bus_read(8'h83, d);
    check("R4", "oversize status error only", 32'(d[2:0]), 32'h2);
    check("R4", "oversize no cs", 32'(cs_falls), 0);
    bus_write(8'h83, 16'h3);
    bus_read(8'h83, d);
    check("R7", "clear-all status", 32'(d[2:0]), 0);
  endtask

  task automatic t_bad_code();
    logic [15:0] d;
    start_cmd(0, 0, 2, 0, 0, 0, 0, 2);
    repeat (40) @(negedge clk);
    bus_read(8'h83, d);
    check("R1", "bad start code status", 32'(d[2:0]), 0);
    check("R1", "bad start code no cs", 32'(cs_falls), 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] d;
    start_cmd(0, 0, 4, 1, 3, 0, 0, 1);
    bus_read(8'h83, d);
    check("R11", "busy while running", 32'(d[2]), 1);
    bus_write(8'h81, 16'(1 | (2 << 8)));
    wait_idle();
    check("R11", "second start ignored cs count", 32'(cs_falls), 1);
    check("R11", "second start ignored cs line", 32'(cs_seen), 32'hD);
    check("R11", "second start ignored byte count", 32'(slave_n), 4);
    bus_write(8'h83, 16'h3);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    bus_write(8'h84, 16'h1);
    start_cmd(0, 0, 1, 0, 0, 0, 0, 1);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R7", "irq with mask set", 32'(irq), 1);
    bus_write(8'h83, 16'h1);
    @(negedge clk);
    check("R7", "irq after clear", 32'(irq), 0);
    bus_write(8'h84, 16'h0);
    start_cmd(0, 0, 1, 0, 0, 0, 0, 1);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R7", "irq masked", 32'(irq), 0);
    bus_read(8'h83, d);
    check("R7", "done set while masked", 32'(d[0]), 1);
    bus_write(8'h83, 16'h3);
  endtask

  task automatic t_rate(input int code, input int exp_ns);
    start_cmd(0, 0, 1, 0, code, 0, 0, 1);
    wait_idle();
    check("R8", $sformatf("sclk period code %0d", code), 32'(t_s1 - t_s0), 32'(exp_ns));
    bus_write(8'h83, 16'h3);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    fill_tx();
    t_full_duplex();
    t_write_prepend();
    t_read_prepend();
    t_full_buffer();
    t_oversize();
    t_bad_code();
    t_busy_ignore();
    t_irq();
    t_rate(0, 8);
    t_rate(3, 64);
    t_rate(7, 512);
    summary();
    $finish;
  end

endmodule